// File: doc/BRIEF.md
# One-Wire Search Triplet Engine

This block carries out a single decision step of a 1-Wire ROM search. On a start strobe it asks an external slot generator for two read slots. The first returns the ID bit of the devices still on the search path. The second returns the complement of that bit. From the two samples and a direction preferred by the caller, the engine picks the branch to follow. It then issues one write slot that carries the chosen direction, so that devices on the other branch drop out.

When the write slot finishes, the engine raises a one-cycle done pulse. At the same time it presents a 3-bit result code. Bit 0 of the code holds the ID bit, bit 1 the complement bit and bit 2 the direction taken. A search loop above the engine calls it 64 times per device and reads the code after each call.

The slot interface has a single bit. A slot request with bit value 0 asks for a write-0 slot. Bit value 1 asks for a write-1 slot, which is also a read slot. The generator acknowledges each slot with a done strobe and, in the same cycle, the sampled bus level.

Top module: `owire_triplet`

## Requirements
- R1: After reset, slot_req_o, done_o and result_o are all zero.
- R2: An accepted step first requests two slots with slot_bit_o = 1 (read slots). The ID bit is the sample returned by the first slot and the complement bit is the sample returned by the second. slot_bit_o holds steady while a request waits for slot_done_i.
- R3: When both samples are 1, the result code is 3'b011.
- R4: When both samples are 0, the direction is the preferred direction and the result code is {pref,0,0}: 4 for preference 1 and 0 for preference 0.
- R5: When exactly one sample is 1, the direction equals the ID bit and the result code is 5 (ID = 1) or 2 (ID = 0).
- R6: The third slot is a write with slot_bit_o equal to the chosen direction. In the R3 case it carries the preferred direction.
- R7: Every step uses exactly three slots. done_o is high for exactly one cycle, in the cycle that follows the clock edge where the third slot's slot_done_i was captured.
- R8: start_i is ignored while a step is in progress, including in the cycle when the third slot completes. No extra slots follow.
- R9: pref_dir_i is sampled only in the cycle when start_i is accepted. Later changes to it do not affect the step.
- R10: result_o holds its value from the end of a step until the next step completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start one triplet step (accepted when idle) |
| pref_dir_i | input | 1 | Direction to take when devices disagree |
| slot_req_o | output | 1 | Slot request, held until slot_done_i |
| slot_bit_o | output | 1 | Slot type: 0 write-0, 1 write-1/read |
| slot_done_i | input | 1 | Slot finished strobe |
| slot_sample_i | input | 1 | Bus sample of the finished slot |
| result_o | output | 3 | {direction, complement bit, ID bit} code |
| done_o | output | 1 | One-cycle step completion pulse |

## Verification
Two events can land in the same clock cycle: the completion of the third slot and a fresh start request. The engine is still busy in that cycle, so the start must be dropped. The bench raises start_i exactly in the cycle its slot model acknowledges the write slot. It then checks that done_o still pulses once at the right time and that no fourth slot is ever requested. A second case raises start_i during the read slots, with pref_dir_i flipped, and checks that neither the slot count nor the chosen direction changes.

// File: rtl/owire_triplet.sv
module owire_triplet (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       pref_dir_i,
  output logic       slot_req_o,
  output logic       slot_bit_o,
  input  logic       slot_done_i,
  input  logic       slot_sample_i,
  output logic [2:0] result_o,
  output logic       done_o
);

  typedef enum logic [1:0] {S_IDLE, S_ID, S_CMP, S_WR} st_t;

  st_t  state;
  logic id_q, cmp_q, pref_q, dir_q;

  assign slot_req_o = (state != S_IDLE);
  assign slot_bit_o = (state == S_WR) ? dir_q : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      id_q     <= 1'b0;
      cmp_q    <= 1'b0;
      pref_q   <= 1'b0;
      dir_q    <= 1'b0;
      result_o <= 3'd0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state)
        S_IDLE: if (start_i) begin
          pref_q <= pref_dir_i;
          state  <= S_ID;
        end
        S_ID: if (slot_done_i) begin
          id_q  <= slot_sample_i;
          state <= S_CMP;
        end
        S_CMP: if (slot_done_i) begin
          cmp_q <= slot_sample_i;
          dir_q <= (id_q ^ slot_sample_i) ? id_q : pref_q;
          state <= S_WR;
        end
        default: if (slot_done_i) begin
          result_o <= (id_q & cmp_q) ? 3'd3 : {dir_q, cmp_q, id_q};
          done_o   <= 1'b1;
          state    <= S_IDLE;
        end
      endcase
    end
  end

  logic [2:0] n_slots;
  always_ff @(posedge clk) begin
    if (!rst_n)                          n_slots <= 3'd0;
    else if (state == S_IDLE && start_i) n_slots <= 3'd0;
    else if (slot_req_o && slot_done_i)  n_slots <= n_slots + 3'd1;
  end

  assert_first_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slot_req_o) |-> slot_bit_o);
  assert_slot_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req_o && !slot_done_i) |=> (slot_req_o && $stable(slot_bit_o)));
  assert_code_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (result_o == 3'd0 || result_o == 3'd2 || result_o == 3'd3 ||
                result_o == 3'd4 || result_o == 3'd5));
  assert_dir_written_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && result_o != 3'd3) |-> ($past(slot_bit_o) == result_o[2]));
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_three_slots_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (n_slots == 3'd3 && !slot_req_o));
  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req_o && start_i) |=> (n_slots >= $past(n_slots)));

endmodule

// File: tb/tb_owire_triplet.sv
`timescale 1ns/1ps
module tb_owire_triplet;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, start_i = 1'b0, pref_dir_i = 1'b0;
  logic slot_done_i = 1'b0, slot_sample_i = 1'b0;
  logic slot_req_o, slot_bit_o, done_o;
  logic [2:0] result_o;

  owire_triplet dut (.clk(clk), .rst_n(rst_n), .start_i(start_i), .pref_dir_i(pref_dir_i),
    .slot_req_o(slot_req_o), .slot_bit_o(slot_bit_o), .slot_done_i(slot_done_i),
    .slot_sample_i(slot_sample_i), .result_o(result_o), .done_o(done_o));

  int total = 0, bad = 0;
  int slot_cnt = 0, wait_c = 0, lat = 0, done_cnt = 0;
  logic rid = 1'b0, rcmp = 1'b0, arm_last = 1'b0, poke_last = 1'b0;
  logic seen0 = 1'b0, seen1 = 1'b0, seen2 = 1'b0;
  logic [2:0] last_res = 3'd0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // slot generator model
  always @(negedge clk) if (rst_n) begin
    if (done_o) begin done_cnt++; last_res = result_o; end
    if (slot_done_i) begin
      slot_done_i = 1'b0;
      if (slot_cnt == 3) chk(done_o == 1'b1, "R7 done timing", done_o, 1);
      if (poke_last) begin start_i = 1'b0; poke_last = 1'b0; end
    end else if (slot_req_o) begin
      if (wait_c >= lat) begin
        if (slot_cnt == 0) seen0 = slot_bit_o;
        if (slot_cnt == 1) seen1 = slot_bit_o;
        if (slot_cnt == 2) seen2 = slot_bit_o;
        slot_sample_i = (slot_cnt == 0) ? rid : (slot_cnt == 1) ? rcmp : slot_bit_o;
        slot_done_i = 1'b1;
        slot_cnt++;
        wait_c = 0;
        if (slot_cnt == 3 && arm_last) begin
          start_i = 1'b1; poke_last = 1'b1; arm_last = 1'b0;
        end
      end else wait_c++;
    end
  end

  task automatic run_step(input logic id, input logic cmp, input logic pref, input int l,
                          input bit mid, input bit last);
    logic err, dir;
    logic [2:0] exp;
    int n;
    err = id & cmp;
    dir = (id ^ cmp) ? id : pref;
    exp = err ? 3'd3 : {dir, cmp, id};
    rid = id; rcmp = cmp; lat = l; slot_cnt = 0; wait_c = 0; done_cnt = 0;
    seen0 = 1'b0; seen1 = 1'b0; seen2 = 1'b0; arm_last = last;
    @(negedge clk); start_i = 1'b1; pref_dir_i = pref;
    @(negedge clk); start_i = 1'b0; pref_dir_i = ~pref;   // R9: later change ignored
    if (mid) begin
      @(negedge clk); start_i = 1'b1;                      // R8: start while busy
      @(negedge clk); start_i = 1'b0;
    end
    n = 0;
    while (done_cnt == 0 && n < 300) begin @(negedge clk); n++; end
    repeat (10) @(negedge clk);
    chk(done_cnt == 1, "R7 one done pulse", done_cnt, 1);
    chk(slot_cnt == 3, "R8 R7 slot count", slot_cnt, 3);
    chk(seen0 && seen1, "R2 read slots", {seen0, seen1}, 3);
    chk(seen2 == dir, "R6 direction slot", seen2, dir);
    if (err)            chk(last_res == exp, "R3 no device code", last_res, exp);
    else if (id == cmp) chk(last_res == exp, "R4 R9 conflict code", last_res, exp);
    else                chk(last_res == exp, "R5 single path code", last_res, exp);
    chk(result_o == exp, "R10 result held", result_o, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(slot_req_o == 1'b0, "R1 reset req", slot_req_o, 0);
    chk(done_o == 1'b0, "R1 reset done", done_o, 0);
    chk(result_o == 3'd0, "R1 reset result", result_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int l = 0; l < 3; l++)
      for (int v = 0; v < 8; v++)
        run_step(v[0], v[1], v[2], l, l == 1, l == 2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule